// File: doc/BRIEF.md
# Half-to-Single Precision Float Widener

This block widens a 16-bit binary floating-point word (1 sign bit, 5 exponent bits, 10 fraction bits) into the equivalent 32-bit binary floating-point word (1 sign bit, 8 exponent bits, 23 fraction bits). Every input pattern has an exact single-precision image, so no rounding takes place and every output bit is fixed by the input.

The input is a data word with a valid strobe. The widened word appears on a registered output one clock later, with its own valid strobe. The datapath sorts each input into one of five classes: zero, subnormal, normal, infinity and NaN. A single `unique case` on that class then builds the result. The class names are ZERO, SUBNORMAL, NORMAL, INFINITE and NOTANUMBER. There is no sequencing between inputs, so the only transition is from one class to the class of the next accepted word. Subnormal inputs are found with a priority-encoded leading-zero count and renormalised into normal single-precision values. NaNs leave the block in quiet form with their payload kept.

Top module: `half_to_single_cvt`

## Requirements
- R1: For a normal input (biased exponent 1..30), the output sign is the input sign (bit 15 to bit 31). The output exponent (bits 30:23) is the input exponent (bits 14:10) plus 112. Output bits 22:13 carry the input fraction (bits 9:0).
- R2: An input with bits 14:0 all zero gives an output with bits 30:0 all zero and bit 31 equal to the input sign.
- R3: An input with exponent 31 and fraction zero gives output exponent 255, output fraction zero, and the same sign.
- R4: An input with exponent 31 and a nonzero fraction gives output exponent 255. Output bit 22 is forced to 1, output bits 21:13 carry input bits 8:0, and the sign is kept.
- R5: Let a subnormal input (exponent 0, fraction nonzero) have k leading zeros in its 10-bit fraction. The output exponent is 112 − k. Output bits 22:13 are the fraction shifted left by k+1 and truncated to 10 bits. The sign is copied to bit 31.
- R6: out_valid equals in_valid of the previous clock. While in_valid is low, out_single keeps its value.
- R7: A synchronous active-low reset clears out_valid and out_single to zero.
- R8: Output bits 12:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_half | input | 16 | Half-precision input word |
| out_valid | output | 1 | Output word was produced from the previous cycle's input |
| out_single | output | 32 | Single-precision result, registered |

## Verification
The bench builds the block with its default widths: a 5-bit/10-bit source format and an 8-bit/23-bit target format. At these widths the input space is only 65536 words, so the bench streams every encoding back to back and checks it against a reference model that renormalises by a shift loop instead of a count. Every subnormal shift distance, every NaN payload and both zero signs are therefore covered. A random phase with gaps in the valid strobe then checks the hold behaviour. A mid-run reset checks the cleared output state.

// File: rtl/hts_pkg.sv
package hts_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBNORMAL,
        CLS_NORMAL,
        CLS_INFINITE,
        CLS_NOTANUMBER
    } hts_class_e;
endpackage

// File: rtl/hts_classify.sv
module hts_classify
    import hts_pkg::*;
#(
    parameter int HE_W = 5,
    parameter int HM_W = 10
) (
    input  logic [HE_W+HM_W:0] word_i,
    output logic               sign_o,
    output logic [HE_W-1:0]    exp_o,
    output logic [HM_W-1:0]    man_o,
    output hts_class_e         cls_o
);
    localparam int HW = 1 + HE_W + HM_W;

    logic exp_max, exp_min, man_nz;

    assign sign_o  = word_i[HW-1];
    assign exp_o   = word_i[HW-2 -: HE_W];
    assign man_o   = word_i[HM_W-1:0];
    assign exp_max = &exp_o;
    assign exp_min = ~|exp_o;
    assign man_nz  = |man_o;

    always_comb begin
        if (exp_max)      cls_o = man_nz ? CLS_NOTANUMBER : CLS_INFINITE;
        else if (exp_min) cls_o = man_nz ? CLS_SUBNORMAL  : CLS_ZERO;
        else              cls_o = CLS_NORMAL;
    end
endmodule

// File: rtl/hts_lzc.sv
module hts_lzc #(
    parameter int W  = 10,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] count_o
);
    always_comb begin
        count_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) count_o = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/hts_assemble.sv
module hts_assemble
    import hts_pkg::*;
#(
    parameter int HE_W = 5,
    parameter int HM_W = 10,
    parameter int SE_W = 8,
    parameter int SM_W = 23,
    parameter int LZ_W = $clog2(HM_W + 1)
) (
    input  logic                sign_i,
    input  logic [HE_W-1:0]     exp_i,
    input  logic [HM_W-1:0]     man_i,
    input  hts_class_e          cls_i,
    input  logic [LZ_W-1:0]     lz_i,
    output logic [SE_W+SM_W:0]  word_o
);
    localparam int BIAS_H = (1 << (HE_W - 1)) - 1;
    localparam int BIAS_S = (1 << (SE_W - 1)) - 1;
    localparam int REBIAS = BIAS_S - BIAS_H;
    localparam int PAD_W  = SM_W - HM_W;

    logic [SE_W-1:0] exp_norm, exp_sub;
    logic [HM_W-1:0] sh_man, frac_sub;
    logic [SM_W-1:0] man_out;
    logic [SE_W-1:0] exp_out;

    assign exp_norm = SE_W'(exp_i) + SE_W'(REBIAS);
    assign exp_sub  = SE_W'(REBIAS) - SE_W'(lz_i);
    assign sh_man   = man_i << lz_i;
    assign frac_sub = {sh_man[HM_W-2:0], 1'b0};

    always_comb begin
        unique case (cls_i)
            CLS_ZERO: begin
                exp_out = '0;
                man_out = '0;
            end
            CLS_SUBNORMAL: begin
                exp_out = exp_sub;
                man_out = {frac_sub, {PAD_W{1'b0}}};
            end
            CLS_NORMAL: begin
                exp_out = exp_norm;
                man_out = {man_i, {PAD_W{1'b0}}};
            end
            CLS_INFINITE: begin
                exp_out = '1;
                man_out = '0;
            end
            CLS_NOTANUMBER: begin
                exp_out = '1;
                man_out = {1'b1, man_i[HM_W-2:0], {PAD_W{1'b0}}};
            end
            default: begin
                exp_out = '0;
                man_out = '0;
            end
        endcase
    end

    assign word_o = {sign_i, exp_out, man_out};
endmodule

// File: rtl/half_to_single_cvt.sv
module half_to_single_cvt
    import hts_pkg::*;
#(
    parameter int HE_W = 5,
    parameter int HM_W = 10,
    parameter int SE_W = 8,
    parameter int SM_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [HE_W+HM_W:0]     in_half,
    output logic                   out_valid,
    output logic [SE_W+SM_W:0]     out_single
);
    localparam int SW   = 1 + SE_W + SM_W;
    localparam int LZ_W = $clog2(HM_W + 1);

    logic            f_sign;
    logic [HE_W-1:0] f_exp;
    logic [HM_W-1:0] f_man;
    hts_class_e      f_cls;
    logic [LZ_W-1:0] f_lz;
    logic [SW-1:0]   wide_next;

    hts_classify #(.HE_W(HE_W), .HM_W(HM_W)) u_classify (
        .word_i (in_half),
        .sign_o (f_sign),
        .exp_o  (f_exp),
        .man_o  (f_man),
        .cls_o  (f_cls)
    );

    hts_lzc #(.W(HM_W), .CW(LZ_W)) u_lzc (
        .vec_i   (f_man),
        .count_o (f_lz)
    );

    hts_assemble #(
        .HE_W(HE_W), .HM_W(HM_W), .SE_W(SE_W), .SM_W(SM_W), .LZ_W(LZ_W)
    ) u_assemble (
        .sign_i (f_sign),
        .exp_i  (f_exp),
        .man_i  (f_man),
        .cls_i  (f_cls),
        .lz_i   (f_lz),
        .word_o (wide_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        out_single <= '0;
        else if (in_valid) out_single <= wide_next;
    end
endmodule

// File: rtl/hts_checker.sv
module hts_checker #(
    parameter int HE_W = 5,
    parameter int HM_W = 10,
    parameter int SE_W = 8,
    parameter int SM_W = 23
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [HE_W+HM_W:0]  in_half,
    input logic                out_valid,
    input logic [SE_W+SM_W:0]  out_single
);
    localparam int HW = 1 + HE_W + HM_W;
    localparam int SW = 1 + SE_W + SM_W;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R6
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R6
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_single)); // R6
    AST_SIGN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_single[SW-1] == $past(in_half[HW-1])); // R1
    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_half[HW-2:0] == '0) |=> out_single[SW-2:0] == '0); // R2
    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_half[HW-2 -: HE_W]) && (|in_half[HM_W-1:0]))
        |=> ((&out_single[SW-2 -: SE_W]) && out_single[SM_W-1])); // R4
    AST_LOW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        out_single[SM_W-HM_W-1:0] == '0); // R8
endmodule

bind half_to_single_cvt hts_checker #(
    .HE_W(HE_W), .HM_W(HM_W), .SE_W(SE_W), .SM_W(SM_W)
) u_hts_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .out_valid  (out_valid),
    .out_single (out_single)
);

// File: tb/sim_half_to_single_cvt.sv
`timescale 1ns/1ps
module sim_half_to_single_cvt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        out_valid;
    logic [31:0] out_single;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] last_out = '0;

    always #2 clk = ~clk;

    half_to_single_cvt u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_half(in_half),
        .out_valid(out_valid), .out_single(out_single)
    );

    function automatic logic [31:0] ref_wide(logic [15:0] h);
        logic s = h[15];
        logic [4:0] e = h[14:10];
        logic [9:0] m = h[9:0];
        logic [10:0] t;
        int k;
        if (e == 5'd31) begin
            if (m == 0) return {s, 8'hFF, 23'd0};
            return {s, 8'hFF, 1'b1, m[8:0], 13'd0};
        end else if (e == 5'd0) begin
            if (m == 0) return {s, 31'd0};
            t = {1'b0, m};
            k = 0;
            while (!t[10]) begin
                t = t << 1;
                k++;
            end
            return {s, 8'(113 - k), t[9:0], 13'd0};
        end
        return {s, 8'(e) + 8'd112, m, 13'd0};
    endfunction

    function automatic string ref_tag(logic [15:0] h);
        if (h[14:10] == 5'd31) return (h[9:0] != 0) ? "R4" : "R3";
        if (h[14:10] == 5'd0)  return (h[9:0] != 0) ? "R5" : "R2";
        return "R1";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [15:0] h, logic v);
        @(negedge clk);
        in_valid = v;
        in_half  = h;
        @(posedge clk);
        #1;
        check("R6", {31'd0, out_valid}, {31'd0, v});
        if (v) begin
            last_out = ref_wide(h);
            check(ref_tag(h), out_single, last_out);
            check("R8", {19'd0, out_single[12:0]}, 32'd0);
        end else begin
            check("R6", out_single, last_out);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        #1;
        check("R7", {31'd0, out_valid}, 32'd0);
        check("R7", out_single, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners: signed zeros, infinities, NaNs, extreme subnormals
        drive(16'h0000, 1'b1); drive(16'h8000, 1'b1);
        drive(16'h7C00, 1'b1); drive(16'hFC00, 1'b1);
        drive(16'h7C01, 1'b1); drive(16'hFE00, 1'b1);
        drive(16'h0001, 1'b1); drive(16'h83FF, 1'b1);
        drive(16'h0400, 1'b1); drive(16'h7BFF, 1'b1);

        // hold while idle with changed data
        drive(16'h3C00, 1'b1);
        drive(16'h1234, 1'b0);
        drive(16'hABCD, 1'b0);

        // exhaustive sweep, back to back
        for (int v = 0; v < 65536; v++) drive(16'(v), 1'b1);

        // random stream with gaps
        for (int i = 0; i < 3000; i++) drive(16'($urandom), ($urandom % 4) != 0);

        // reset in mid-stream
        drive(16'h5555, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R7", {31'd0, out_valid}, 32'd0);
        check("R7", out_single, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        last_out = '0;
        drive(16'h0200, 1'b1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule